// File: doc/BRIEF.md
# Transmit DMA Channel Controller

This block governs the transmit channel of a descriptor-driven DMA engine that feeds a network MAC. It takes host command writes and handshakes from the descriptor processor. From these it decides whether the channel may move data, when a halt actually takes effect, and how the channel is torn down and restarted. The command write carries three bits: a self-clearing channel reset, a one-shot transmit disable, and a level that selects the underrun policy.

A disable that arrives while a frame is in flight is deferred. The channel stays active until the descriptor processor reports that the frame's status has been written back. When the underrun policy is enabled, a transmit underrun starts a fixed sequence in three separate cycles: the channel stops first, the descriptor queue is then flushed, and the host's enqueue count is then cleared. A channel reset holds the FIFO and descriptor processor in reset for a parameterised number of cycles. It overrides every other command.

Top module: `txdma_chan_ctrl`

## Requirements
- R1: After `rst_n` is released, `tx_active` is 1 and `desc_flush`, `enq_clr`, `chan_rst_out`, `rd_chan_rst` and `rd_uhalt` are all 0.
- R2: A disable write (`wr_en` with `wr_tx_dis`=1) while no frame is in progress drops `tx_active` to 0 in the cycle after the write.
- R3: A channel-reset write (`wr_en` with `wr_chan_rst`=1) raises `chan_rst_out` and `rd_chan_rst` in the cycle after the write and holds them for exactly RST_CYCLES (default 4) cycles. Both then return to 0, and `tx_active` returns to 1.
- R4: A disable write made after `frame_start` and before `status_done` leaves `tx_active` at 1. `tx_active` falls in the cycle after `status_done` is sampled.
- R5: `rd_tx_dis` reads 0 in every cycle, including the cycle right after a disable write.
- R6: With the underrun policy set, an `underrun` during a frame drops `tx_active` in the next cycle. `desc_flush` pulses for one cycle in the cycle after that, and `enq_clr` pulses for one cycle in the cycle after that.
- R7: With the underrun policy clear, `underrun` has no effect. `tx_active` stays 1, no flush or clear is issued, and the next `frame_start` is accepted.
- R8: Once halted, the channel stays halted and ignores `frame_start` until `enq_valid` is asserted. `tx_active` then returns to 1 in the next cycle, with no frame in progress.
- R9: Every command write loads the underrun policy from `wr_uhalt`. `rd_uhalt` shows the new value from the cycle after the write.
- R10: A channel-reset write takes priority over a disable in the same write, and it aborts an underrun sequence already under way. No later `desc_flush` or `enq_clr` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command write strobe |
| wr_chan_rst | input | 1 | Write data: request channel reset |
| wr_tx_dis | input | 1 | Write data: request transmit disable |
| wr_uhalt | input | 1 | Write data: underrun-halt policy value |
| enq_valid | input | 1 | Host enqueued new descriptors |
| frame_start | input | 1 | Descriptor processor began a frame |
| status_done | input | 1 | Current frame's status written back |
| underrun | input | 1 | Transmit FIFO underrun |
| tx_active | output | 1 | Channel is running |
| desc_flush | output | 1 | One-cycle flush strobe to the descriptor queue |
| enq_clr | output | 1 | One-cycle clear of the enqueue count |
| chan_rst_out | output | 1 | Reset to transmit FIFO and descriptor processor |
| rd_chan_rst | output | 1 | Readback of the self-clearing reset bit |
| rd_tx_dis | output | 1 | Readback of the disable bit |
| rd_uhalt | output | 1 | Readback of the underrun policy |

## Verification
Several properties are checked in every cycle. The flush strobe never coincides with an active channel, and a clear always follows a flush. Reset pulses last exactly the configured length. An idle, halted channel never wakes up without an enqueue or a reset, and an active channel never drops without a status write-back, an underrun or a command as its cause. The directed scenarios cover the rest: the deferral of a disable until the status write-back, the policy readback, the cycle-exact position of each step of the underrun sequence, the discarding of a frame start while halted, and the abort of a flush by a reset.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_ACTIVE    = 3'd1,
      ST_HALT_PEND = 3'd2,
      ST_HALTED    = 3'd3,
      ST_FLUSH     = 3'd4,
      ST_RESETTING = 3'd5
   } chan_state_e;

   typedef enum logic [1:0] {
      PH_OFF   = 2'd0,
      PH_STOP  = 2'd1,
      PH_FLUSH = 2'd2,
      PH_CLEAR = 2'd3
   } flush_phase_e;

   typedef struct packed {
      logic rst;
      logic dis;
   } chan_cmd_t;
endpackage

// File: rtl/txdma_cmd_regs.sv
module txdma_cmd_regs #(
   parameter bit UHALT_RESET = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_chan_rst,
   input  logic                wr_tx_dis,
   input  logic                wr_uhalt,
   output txdma_pkg::chan_cmd_t cmd,
   output logic                uhalt
);
   logic uhalt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     uhalt_q <= UHALT_RESET;
      else if (wr_en) uhalt_q <= wr_uhalt;
   end

   always_comb begin
      cmd.rst = wr_en & wr_chan_rst;
      cmd.dis = wr_en & wr_tx_dis & ~wr_chan_rst;
   end

   assign uhalt = uhalt_q;
endmodule

// File: rtl/txdma_rst_timer.sv
module txdma_rst_timer #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic last
);
   localparam int CNT_W = $clog2(RST_CYCLES + 1);

   generate
      if (RST_CYCLES == 1) begin : g_single
         logic unused_start;
         assign unused_start = start;
         assign last = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (start)          cnt_q <= CNT_W'(RST_CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
         end
         assign last = (cnt_q == CNT_W'(1));
      end
   endgenerate
endmodule

// File: rtl/txdma_flush_seq.sv
module txdma_flush_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic flush,
   output logic clear,
   output logic done
);
   import txdma_pkg::*;
   flush_phase_e ph_q, ph_d;

   always_comb begin
      ph_d = ph_q;
      if (abort)      ph_d = PH_OFF;
      else if (start) ph_d = PH_STOP;
      else begin
         unique case (ph_q)
            PH_STOP:  ph_d = PH_FLUSH;
            PH_FLUSH: ph_d = PH_CLEAR;
            PH_CLEAR: ph_d = PH_OFF;
            default:  ph_d = PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_OFF;
      else        ph_q <= ph_d;
   end

   assign flush = (ph_q == PH_FLUSH);
   assign clear = (ph_q == PH_CLEAR);
   assign done  = (ph_q == PH_CLEAR);
endmodule

// File: rtl/txdma_seq_fsm.sv
module txdma_seq_fsm (
   input  logic                 clk,
   input  logic                 rst_n,
   input  txdma_pkg::chan_cmd_t cmd,
   input  logic                 uhalt,
   input  logic                 enq_valid,
   input  logic                 frame_start,
   input  logic                 status_done,
   input  logic                 underrun,
   input  logic                 timer_last,
   input  logic                 flush_done,
   output txdma_pkg::chan_state_e state,
   output logic                 start_timer,
   output logic                 start_flush
);
   import txdma_pkg::*;
   chan_state_e st_q, st_d;
   logic        uh_hit;

   assign uh_hit = underrun & uhalt;

   always_comb begin
      st_d        = st_q;
      start_timer = 1'b0;
      start_flush = 1'b0;
      if (cmd.rst) begin
         st_d        = ST_RESETTING;
         start_timer = 1'b1;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (cmd.dis)          st_d = ST_HALTED;
               else if (frame_start) st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
               if (uh_hit) begin
                  st_d        = ST_FLUSH;
                  start_flush = 1'b1;
               end else if (status_done) st_d = cmd.dis ? ST_HALTED : ST_IDLE;
               else if (cmd.dis)         st_d = ST_HALT_PEND;
            end
            ST_HALT_PEND: begin
               if (uh_hit) begin
                  st_d        = ST_FLUSH;
                  start_flush = 1'b1;
               end else if (status_done) st_d = ST_HALTED;
            end
            ST_HALTED:    if (enq_valid)  st_d = ST_IDLE;
            ST_FLUSH:     if (flush_done) st_d = ST_HALTED;
            ST_RESETTING: if (timer_last) st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state = st_q;
endmodule

// File: rtl/txdma_chan_ctrl.sv
module txdma_chan_ctrl #(
   parameter int RST_CYCLES  = 4,
   parameter bit UHALT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_chan_rst,
   input  logic wr_tx_dis,
   input  logic wr_uhalt,
   input  logic enq_valid,
   input  logic frame_start,
   input  logic status_done,
   input  logic underrun,
   output logic tx_active,
   output logic desc_flush,
   output logic enq_clr,
   output logic chan_rst_out,
   output logic rd_chan_rst,
   output logic rd_tx_dis,
   output logic rd_uhalt
);
   import txdma_pkg::*;

   generate
      if (RST_CYCLES < 1) begin : g_bad_rst_cycles
         $error("txdma_chan_ctrl: RST_CYCLES must be at least 1");
      end
   endgenerate

   chan_cmd_t   cmd;
   logic        uhalt;
   chan_state_e state;
   logic        start_timer, start_flush, timer_last;
   logic        seq_flush, seq_clear, seq_done;

   txdma_cmd_regs #(.UHALT_RESET(UHALT_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan_rst(wr_chan_rst),
      .wr_tx_dis(wr_tx_dis), .wr_uhalt(wr_uhalt), .cmd(cmd), .uhalt(uhalt)
   );

   txdma_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_timer), .last(timer_last)
   );

   txdma_flush_seq u_flush (
      .clk(clk), .rst_n(rst_n), .start(start_flush), .abort(cmd.rst),
      .flush(seq_flush), .clear(seq_clear), .done(seq_done)
   );

   txdma_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .uhalt(uhalt),
      .enq_valid(enq_valid), .frame_start(frame_start),
      .status_done(status_done), .underrun(underrun),
      .timer_last(timer_last), .flush_done(seq_done),
      .state(state), .start_timer(start_timer), .start_flush(start_flush)
   );

   assign tx_active    = (state == ST_IDLE) || (state == ST_ACTIVE) ||
                         (state == ST_HALT_PEND);
   assign desc_flush   = seq_flush & (state == ST_FLUSH);
   assign enq_clr      = seq_clear & (state == ST_FLUSH);
   assign chan_rst_out = (state == ST_RESETTING);
   assign rd_chan_rst  = chan_rst_out;
   assign rd_tx_dis    = 1'b0;
   assign rd_uhalt     = uhalt;
endmodule

// File: rtl/txdma_chan_ctrl_chk.sv
module txdma_chan_ctrl_chk #(
   parameter int RST_CYCLES = 4
) (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic wr_chan_rst,
   input logic wr_tx_dis,
   input logic enq_valid,
   input logic status_done,
   input logic underrun,
   input logic rd_uhalt,
   input logic tx_active,
   input logic desc_flush,
   input logic enq_clr,
   input logic chan_rst_out
);
   logic rst_cmd;
   int   run_q;
   assign rst_cmd = wr_en & wr_chan_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run_q <= 0;
      else if (rst_cmd)      run_q <= 1;
      else if (chan_rst_out) run_q <= run_q + 1;
      else                   run_q <= 0;
   end

   p_rst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_rst_out) |-> ($past(run_q) == RST_CYCLES));

   p_rst_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst_out |-> (!tx_active && !desc_flush && !enq_clr));

   p_flush_after_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_flush |-> (!tx_active && $past(!tx_active)));

   p_clear_follows_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_flush && !rst_cmd) |=> enq_clr);

   p_clear_needs_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      enq_clr |-> $past(desc_flush));

   p_stay_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_active && !chan_rst_out && !enq_valid && !rst_cmd) |=> !tx_active);

   p_drop_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_active) |-> $past(status_done || underrun ||
                                 (wr_en && (wr_chan_rst || wr_tx_dis))));

   p_underrun_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_active && underrun && !rd_uhalt && !status_done && !wr_en) |=> tx_active);
endmodule

bind txdma_chan_ctrl txdma_chan_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan_rst(wr_chan_rst),
   .wr_tx_dis(wr_tx_dis), .enq_valid(enq_valid), .status_done(status_done),
   .underrun(underrun), .rd_uhalt(rd_uhalt), .tx_active(tx_active),
   .desc_flush(desc_flush), .enq_clr(enq_clr), .chan_rst_out(chan_rst_out)
);

// File: tb/tb_txdma_chan_ctrl.sv
`timescale 1ns/1ps
module tb_txdma_chan_ctrl;
   localparam int RST_CYCLES = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0, wr_chan_rst = 0, wr_tx_dis = 0, wr_uhalt = 0;
   logic enq_valid = 0, frame_start = 0, status_done = 0, underrun = 0;
   logic tx_active, desc_flush, enq_clr, chan_rst_out;
   logic rd_chan_rst, rd_tx_dis, rd_uhalt;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   txdma_chan_ctrl #(.RST_CYCLES(RST_CYCLES)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan_rst(wr_chan_rst),
      .wr_tx_dis(wr_tx_dis), .wr_uhalt(wr_uhalt), .enq_valid(enq_valid),
      .frame_start(frame_start), .status_done(status_done), .underrun(underrun),
      .tx_active(tx_active), .desc_flush(desc_flush), .enq_clr(enq_clr),
      .chan_rst_out(chan_rst_out), .rd_chan_rst(rd_chan_rst),
      .rd_tx_dis(rd_tx_dis), .rd_uhalt(rd_uhalt)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_wr(input bit r, input bit d, input bit u);
      wr_en = 1; wr_chan_rst = r; wr_tx_dis = d; wr_uhalt = u;
      tick();
      wr_en = 0; wr_chan_rst = 0; wr_tx_dis = 0; wr_uhalt = 0;
   endtask

   task automatic pulse_frame();   frame_start = 1; tick(); frame_start = 0; endtask
   task automatic pulse_status();  status_done = 1; tick(); status_done = 0; endtask
   task automatic pulse_underrun(); underrun   = 1; tick(); underrun   = 0; endtask
   task automatic pulse_enq();     enq_valid   = 1; tick(); enq_valid   = 0; endtask

   task automatic t_reset_state();
      chk("R1", "tx_active", tx_active, 1);
      chk("R1", "desc_flush", desc_flush, 0);
      chk("R1", "enq_clr", enq_clr, 0);
      chk("R1", "chan_rst_out", chan_rst_out, 0);
      chk("R1", "rd_chan_rst", rd_chan_rst, 0);
      chk("R1", "rd_uhalt", rd_uhalt, 0);
   endtask

   task automatic t_chan_reset();
      do_wr(1, 0, 0);
      for (int i = 0; i < RST_CYCLES; i++) begin
         chk("R3", "chan_rst_out held", chan_rst_out, 1);
         chk("R3", "rd_chan_rst held", rd_chan_rst, 1);
         tick();
      end
      chk("R3", "chan_rst_out released", chan_rst_out, 0);
      chk("R3", "rd_chan_rst self-cleared", rd_chan_rst, 0);
      chk("R3", "tx_active after reset", tx_active, 1);
   endtask

   task automatic t_disable_idle();
      do_wr(0, 1, 0);
      chk("R2", "tx_active after idle disable", tx_active, 0);
      chk("R5", "rd_tx_dis after write", rd_tx_dis, 0);
      pulse_enq();
      chk("R8", "tx_active after enqueue", tx_active, 1);
   endtask

   task automatic t_disable_in_frame();
      pulse_frame();
      do_wr(0, 1, 0);
      chk("R5", "rd_tx_dis after write", rd_tx_dis, 0);
      chk("R4", "tx_active held in frame", tx_active, 1);
      tick(); tick();
      chk("R4", "tx_active still held", tx_active, 1);
      pulse_status();
      chk("R4", "tx_active after status", tx_active, 0);
      pulse_enq();
      chk("R8", "tx_active after enqueue", tx_active, 1);
   endtask

   task automatic t_underrun_halt();
      do_wr(0, 0, 1);
      chk("R9", "rd_uhalt set", rd_uhalt, 1);
      pulse_frame();
      pulse_underrun();
      chk("R6", "tx_active halted first", tx_active, 0);
      chk("R6", "no flush in halt cycle", desc_flush, 0);
      chk("R6", "no clear in halt cycle", enq_clr, 0);
      tick();
      chk("R6", "flush cycle desc_flush", desc_flush, 1);
      chk("R6", "flush cycle enq_clr", enq_clr, 0);
      tick();
      chk("R6", "clear cycle desc_flush", desc_flush, 0);
      chk("R6", "clear cycle enq_clr", enq_clr, 1);
      tick();
      chk("R6", "enq_clr one cycle", enq_clr, 0);
      tick(); tick();
      chk("R8", "stays halted", tx_active, 0);
      pulse_frame();
      chk("R8", "frame_start ignored when halted", tx_active, 0);
      pulse_enq();
      chk("R8", "resume after enqueue", tx_active, 1);
      do_wr(0, 1, 1);
      chk("R8", "no frame in flight after resume", tx_active, 0);
      pulse_enq();
   endtask

   task automatic t_underrun_ignored();
      do_wr(0, 0, 0);
      chk("R9", "rd_uhalt cleared", rd_uhalt, 0);
      pulse_frame();
      pulse_underrun();
      chk("R7", "tx_active after underrun", tx_active, 1);
      chk("R7", "no flush", desc_flush, 0);
      tick();
      chk("R7", "no flush later", desc_flush, 0);
      chk("R7", "no clear later", enq_clr, 0);
      pulse_status();
      pulse_frame();
      chk("R7", "next frame accepted", tx_active, 1);
      pulse_status();
   endtask

   task automatic t_reset_priority();
      pulse_frame();
      do_wr(1, 1, 1);
      chk("R10", "reset wins over disable", chan_rst_out, 1);
      chk("R9", "policy loaded with reset", rd_uhalt, 1);
      repeat (RST_CYCLES) tick();
      chk("R10", "active after reset", tx_active, 1);
      pulse_frame();
      pulse_underrun();
      tick();
      chk("R10", "flush under way", desc_flush, 1);
      do_wr(1, 0, 1);
      chk("R10", "reset aborts flush", chan_rst_out, 1);
      chk("R10", "no clear after abort", enq_clr, 0);
      tick();
      chk("R10", "no flush after abort", desc_flush, 0);
      repeat (RST_CYCLES - 1) tick();
      chk("R10", "active after abort reset", tx_active, 1);
      chk("R10", "clear never issued", enq_clr, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      t_reset_state();
      t_chan_reset();
      t_disable_idle();
      t_disable_in_frame();
      t_underrun_halt();
      t_underrun_ignored();
      t_reset_priority();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule